// File: doc/BRIEF.md
# Multi-Channel Quadrature Counter Bank

This block turns incremental encoder signals into position counts. Six input pins, arranged as three pairs `pin_p[k]` and `pin_n[k]`, are routed to up to three counter channels. Each channel receives an A/B quadrature pair and sometimes an index Z. A channel-count mode decides how the pins are routed, together with a flag that says whether the receivers deliver one single-ended signal per pin or one resolved differential pair per P/N couple. Every channel counts all four edges of its quadrature cycle into a 48-bit two's-complement position. An active index level clears that position.

A byte-wide register port holds the configuration. Each channel has an A/B swap bit that reverses its counting sense. Channels 0 and 1 each have an index polarity bit. Changing the channel mode or the input type restarts every channel from zero. A status output reports which differential standard is selected while differential operation is in effect. Illegal quadrature steps, where A and B both change in one sample, leave the count unchanged. Each such step latches a sticky error flag for its channel.

Top module: `quad_counter_bank`

## Requirements
- R1: Register reads return the fields at their fixed positions. Address 0x00 holds swap bits for channels 0, 1 and 2 at bits 3, 4 and 5, and index polarity bits for channels 0 and 1 at bits 6 and 7; bits 2:0 always read 0. Address 0x01 holds the input type at bit 7 (0 differential, 1 single-ended) and the channel mode at bits 1:0 (0 one channel, 1 two, 2 three, 3 treated as one). Address 0x03 holds the differential standard at bit 7. Every other bit, and every other address, reads 0. All fields reset to 0.
- R2: With swap clear, a channel counts up by one per edge when A leads B: (A,B) goes 00, 10, 11, 01, 00. It counts down for the reverse order. A pin change shows on the count on the third rising clock edge after it is applied.
- R3: With a channel's swap bit set, A and B are exchanged, so the sequence that counted up now counts down.
- R4: When A and B change in the same sample, the count holds and that channel's error flag `err[i]` goes to 1. The flag stays 1 until reset or a mode change.
- R5: An active index level clears the channel count on the next clock and holds it at zero while it stays active. The index is active high when the polarity bit is 0 and active low when it is 1.
- R6: One channel, single-ended: channel 0 takes A=P0, B=N0 and Z=P1.
- R7: One channel, differential: channel 0 takes A from pair 0, B from pair 1 and Z from pair 2, read on the P side. The N pins have no effect.
- R8: Two channels: pins P0, N0, P1, N1, P2, N2 feed A0, B0, Z0, A1, B1, Z1 in that order.
- R9: Three channels: A0=P0, B0=N0, A1=P1, B1=N1, A2=P2, B2=N2. No channel has an index, and the polarity bits have no effect.
- R10: A change of channel mode or input type clears all counts and error flags. Differential routing applies only in one-channel mode. In the other modes the input-type bit is ignored and single-ended routing is used.
- R11: Counts are 48-bit two's complement and wrap. Counting down from zero gives all ones.
- R12: `lvds_sel` equals the standard bit only while differential one-channel operation is in effect. Otherwise it is 0.
- R13: Channels that the current mode does not use hold a count of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational on address) |
| pin_p | input | 3 | P side of the three input pin pairs |
| pin_n | input | 3 | N side of the three input pin pairs |
| count0 | output | CW | Channel 0 position |
| count1 | output | CW | Channel 1 position |
| count2 | output | CW | Channel 2 position |
| err | output | 3 | Sticky illegal-transition flags, one per channel |
| lvds_sel | output | 1 | Selected differential standard while differential operation is active |

## Verification
The hardest situation to reach from the ports is an illegal transition. Both routed A and B must flip in the same synchronizer sample. A bench cannot arrange that with real encoder timing. The bench instead changes both pins on the same falling clock edge, so the two synchronizer chains carry the change together. It then follows with legal steps to show that the count resumes from its held value while the flag stays set. A second hard case is an index polarity change while the index pin is idle. The bench flips the polarity bit with the pin at 0, which makes the index active at once, and then drives quadrature steps to confirm the count stays pinned at zero.

// File: rtl/quad_counter_bank.sv
module quad_counter_bank #(
  parameter int CW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_addr,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic [2:0]    pin_p,
  input  logic [2:0]    pin_n,
  output logic [CW-1:0] count0,
  output logic [CW-1:0] count1,
  output logic [CW-1:0] count2,
  output logic [2:0]    err,
  output logic          lvds_sel
);

  localparam logic [1:0] NCH_ONE = 2'd0;
  localparam logic [1:0] NCH_TWO = 2'd1;
  localparam logic [CW-1:0] STEP = CW'(1);

  logic [2:0] swap_r;
  logic [1:0] zinv_r;
  logic       single_r;
  logic [1:0] mode_r;
  logic       std_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swap_r   <= '0;
      zinv_r   <= '0;
      single_r <= 1'b0;
      mode_r   <= '0;
      std_r    <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        8'h00: begin
          swap_r <= cfg_wdata[5:3];
          zinv_r <= cfg_wdata[7:6];
        end
        8'h01: begin
          single_r <= cfg_wdata[7];
          mode_r   <= cfg_wdata[1:0];
        end
        8'h03: std_r <= cfg_wdata[7];
        default: ;
      endcase
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^{cfg_wdata[2:0], cfg_wdata[6:2]};

  always_comb begin
    case (cfg_addr)
      8'h00:   cfg_rdata = {zinv_r, swap_r, 3'b000};
      8'h01:   cfg_rdata = {single_r, 5'b00000, mode_r};
      8'h03:   cfg_rdata = {std_r, 7'b0000000};
      default: cfg_rdata = 8'h00;
    endcase
  end

  logic [1:0] nch;
  logic       diff;
  logic [2:0] key, key_q;
  logic       key_chg;

  assign nch      = (mode_r == 2'd3) ? NCH_ONE : mode_r;
  assign diff     = !single_r && (nch == NCH_ONE);
  assign key      = {diff, nch};
  assign key_chg  = key != key_q;
  assign lvds_sel = std_r && diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= 3'b100;
    else        key_q <= key;
  end

  logic [2:0] p_s1, p_s2, n_s1, n_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_s1 <= '0; p_s2 <= '0; n_s1 <= '0; n_s2 <= '0;
    end else begin
      p_s1 <= pin_p; p_s2 <= p_s1;
      n_s1 <= pin_n; n_s2 <= n_s1;
    end
  end

  logic [2:0] ra, rb, rz, has_z;

  always_comb begin
    ra = '0; rb = '0; rz = '0; has_z = '0;
    case (nch)
      NCH_ONE: begin
        has_z[0] = 1'b1;
        ra[0]    = p_s2[0];
        if (diff) begin
          rb[0] = p_s2[1];
          rz[0] = p_s2[2];
        end else begin
          rb[0] = n_s2[0];
          rz[0] = p_s2[1];
        end
      end
      NCH_TWO: begin
        has_z = 3'b011;
        ra[0] = p_s2[0]; rb[0] = n_s2[0]; rz[0] = p_s2[1];
        ra[1] = n_s2[1]; rb[1] = p_s2[2]; rz[1] = n_s2[2];
      end
      default: begin
        ra = p_s2;
        rb = n_s2;
      end
    endcase
  end

  logic [2:0] prev_a, prev_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_a <= '0;
      prev_b <= '0;
    end else begin
      prev_a <= ra;
      prev_b <= rb;
    end
  end

  logic [2:0] zinv3, zact, bad;
  logic [CW-1:0] cnt [3];
  logic          err_r [3];

  assign zinv3 = {1'b0, zinv_r};
  assign zact  = has_z & (rz ^ zinv3);

  for (genvar i = 0; i < 3; i++) begin : g_ch
    logic ca, cb, pa, pb, moved, up;

    assign ca    = swap_r[i] ? rb[i] : ra[i];
    assign cb    = swap_r[i] ? ra[i] : rb[i];
    assign pa    = swap_r[i] ? prev_b[i] : prev_a[i];
    assign pb    = swap_r[i] ? prev_a[i] : prev_b[i];
    assign moved = (ca ^ pa) ^ (cb ^ pb);
    assign bad[i] = (ca ^ pa) & (cb ^ pb);
    assign up    = pa == cb;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt[i]   <= '0;
        err_r[i] <= 1'b0;
      end else if (key_chg) begin
        cnt[i]   <= '0;
        err_r[i] <= 1'b0;
      end else begin
        err_r[i] <= err_r[i] | bad[i];
        if (zact[i])    cnt[i] <= '0;
        else if (moved) cnt[i] <= up ? cnt[i] + STEP : cnt[i] - STEP;
      end
    end
  end

  assign count0 = cnt[0];
  assign count1 = cnt[1];
  assign count2 = cnt[2];
  assign err    = {err_r[2], err_r[1], err_r[0]};

endmodule

// File: rtl/quad_counter_bank_chk.sv
module quad_counter_bank_chk #(
  parameter int CW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    nch,
  input logic          key_chg,
  input logic [2:0]    zact,
  input logic [2:0]    bad,
  input logic [CW-1:0] count0,
  input logic [CW-1:0] count1,
  input logic [CW-1:0] count2,
  input logic [2:0]    err
);

  localparam logic [CW-1:0] ONE = CW'(1);

  AST_STEP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (count0 != $past(count0)) |-> (count0 == '0 || count0 == $past(count0) + ONE || count0 == $past(count0) - ONE)); // R2

  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bad[0] && !zact[0] && !key_chg) |=> $stable(count0)); // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err[0] && !key_chg) |=> err[0]); // R4

  AST_INDEX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    zact[0] |=> (count0 == '0)); // R5

  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    key_chg |=> (count0 == '0 && count1 == '0 && count2 == '0 && err == 3'b000)); // R10

  AST_NO_INDEX_3CH: assert property (@(posedge clk) disable iff (!rst_n)
    (nch == 2'd2) |-> (zact == 3'b000)); // R9

  AST_IDLE_CH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (nch == 2'd0) |=> (count1 == '0 && count2 == '0)); // R13

  AST_IDLE_CH_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (nch == 2'd1) |=> (count2 == '0)); // R13

endmodule

bind quad_counter_bank quad_counter_bank_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .nch(nch), .key_chg(key_chg), .zact(zact),
  .bad(bad), .count0(count0), .count1(count1), .count2(count2), .err(err)
);

// File: tb/quad_counter_bank_bench.sv
`timescale 1ns/1ps
module quad_counter_bank_bench;

  localparam int CW = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0, cfg_wdata = '0, cfg_rdata;
  logic [2:0] pin_p = '0, pin_n = '0;
  logic [CW-1:0] count0, count1, count2;
  logic [2:0] err;
  logic lvds_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  quad_counter_bank #(.CW(CW)) u_quad_counter_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pin_p(pin_p), .pin_n(pin_n),
    .count0(count0), .count1(count1), .count2(count2), .err(err), .lvds_sel(lvds_sel)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(req, 64'(cfg_rdata), 64'(exp));
  endtask

  // sel: 0 A=P0,B=N0  1 A=P0,B=P1  2 A=N1,B=P2  3 A=P1,B=N1  4 A=P2,B=N2
  task automatic put(input int sel, input logic a, input logic b);
    @(negedge clk);
    case (sel)
      0: begin pin_p[0] = a; pin_n[0] = b; end
      1: begin pin_p[0] = a; pin_p[1] = b; end
      2: begin pin_n[1] = a; pin_p[2] = b; end
      3: begin pin_p[1] = a; pin_n[1] = b; end
      default: begin pin_p[2] = a; pin_n[2] = b; end
    endcase
    repeat (3) @(negedge clk);
  endtask

  task automatic spin(input int sel, input int n, input bit fwd);
    for (int k = 1; k <= n; k++) begin
      int ph = k % 4;
      logic x = (ph == 1 || ph == 2);
      logic y = (ph == 2 || ph == 3);
      if (fwd) put(sel, x, y);
      else     put(sel, y, x);
    end
  endtask

  task automatic zero_pins();
    @(negedge clk);
    pin_p = '0; pin_n = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    rd("R1", 8'h00, 8'h00);
    rd("R1", 8'h01, 8'h00);
    rd("R1", 8'h03, 8'h00);
    chk("R13", 64'(count0 | count1 | count2), 0);
    chk("R4", 64'(err), 0);
    chk("R12", 64'(lvds_sel), 0);
  endtask

  task automatic t_regs();
    wr(8'h00, 8'hFF);
    rd("R1", 8'h00, 8'hF8);
    wr(8'h00, 8'h00);
    wr(8'h02, 8'hFF);
    rd("R1", 8'h02, 8'h00);
    rd("R1", 8'h01, 8'h00);
  endtask

  task automatic t_diff_one();
    spin(1, 8, 1);
    chk("R7", 64'(count0), 8);
    @(negedge clk); pin_n = 3'b101; repeat (3) @(negedge clk);
    @(negedge clk); pin_n = 3'b010; repeat (3) @(negedge clk);
    chk("R7", 64'(count0), 8);
    @(negedge clk); pin_n = '0; repeat (3) @(negedge clk);
    spin(1, 12, 0);
    chk("R11", 64'(count0), 64'(48'hFFFF_FFFF_FFFC));
    put(1, 1'b0, 1'b0);
    @(negedge clk); pin_p[2] = 1'b1; repeat (3) @(negedge clk);
    chk("R5", 64'(count0), 0);
    @(negedge clk); pin_p[2] = 1'b0; repeat (3) @(negedge clk);
    wr(8'h03, 8'h80);
    chk("R12", 64'(lvds_sel), 1);
    spin(1, 4, 1);
    wr(8'h01, 8'h80);
    chk("R12", 64'(lvds_sel), 0);
    chk("R10", 64'(count0), 0);
  endtask

  task automatic t_se_one();
    @(negedge clk); pin_p[0] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2", 64'(count0), 0);
    @(negedge clk);
    chk("R2", 64'(count0), 1);
    put(0, 1'b1, 1'b1); put(0, 1'b0, 1'b1); put(0, 1'b0, 1'b0);
    chk("R6", 64'(count0), 4);
    wr(8'h00, 8'h08);
    spin(0, 4, 1);
    chk("R3", 64'(count0), 0);
    spin(0, 8, 0);
    chk("R3", 64'(count0), 8);
    wr(8'h00, 8'h00);
    spin(0, 4, 0);
    chk("R2", 64'(count0), 4);
    wr(8'h00, 8'h40);
    chk("R5", 64'(count0), 0);
    spin(0, 4, 1);
    chk("R5", 64'(count0), 0);
    @(negedge clk); pin_p[1] = 1'b1; repeat (3) @(negedge clk);
    spin(0, 4, 1);
    chk("R6", 64'(count0), 4);
    wr(8'h00, 8'h00);
    chk("R5", 64'(count0), 0);
    @(negedge clk); pin_p[1] = 1'b0; repeat (3) @(negedge clk);
    spin(0, 4, 1);
    put(0, 1'b1, 1'b1);
    chk("R4", 64'(count0), 4);
    chk("R4", 64'(err), 3'b001);
    put(0, 1'b0, 1'b1); put(0, 1'b0, 1'b0);
    chk("R4", 64'(count0), 6);
    chk("R4", 64'(err), 3'b001);
  endtask

  task automatic t_two();
    zero_pins();
    wr(8'h01, 8'h81);
    chk("R10", 64'(count0), 0);
    chk("R10", 64'(err), 0);
    spin(0, 4, 1);
    spin(2, 8, 1);
    chk("R8", 64'(count0), 4);
    chk("R8", 64'(count1), 8);
    chk("R13", 64'(count2), 0);
    @(negedge clk); pin_n[2] = 1'b1; repeat (3) @(negedge clk);
    chk("R8", 64'(count1), 0);
    chk("R8", 64'(count0), 4);
    @(negedge clk); pin_n[2] = 1'b0; repeat (3) @(negedge clk);
    spin(2, 4, 0);
    wr(8'h00, 8'h80);
    chk("R5", 64'(count1), 0);
    wr(8'h00, 8'h00);
    wr(8'h03, 8'h80);
    wr(8'h01, 8'h01);
    chk("R12", 64'(lvds_sel), 0);
    spin(2, 4, 1);
    chk("R10", 64'(count1), 4);
  endtask

  task automatic t_three();
    zero_pins();
    wr(8'h01, 8'h82);
    chk("R10", 64'(count1), 0);
    spin(0, 4, 1);
    spin(3, 8, 1);
    spin(4, 4, 0);
    chk("R9", 64'(count0), 4);
    chk("R9", 64'(count1), 8);
    chk("R9", 64'(count2), 64'(48'hFFFF_FFFF_FFFC));
    wr(8'h00, 8'hC0);
    chk("R9", 64'(count0), 4);
    chk("R9", 64'(count1), 8);
    spin(3, 4, 1);
    chk("R9", 64'(count1), 12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_regs();
    t_diff_one();
    t_se_one();
    t_two();
    t_three();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule